// File: doc/BRIEF.md
# Four-Wide Chained Integer Issue Stage

This block executes a bundle of four consecutive 32-bit integer instructions in one clock cycle. Each of the four slots is a purely combinational ALU. The results are written into a 32-entry register file at the next rising edge, with up to four writes at once. A slot that reads a register written by an earlier slot of the same bundle takes that freshly computed value through a combinational forwarding chain. A run of dependent operations therefore still retires in a single cycle.

The stage decodes a small register-register and register-immediate subset. It does not execute loads, stores, branches or jumps. It only detects them and tells the surrounding fetch and memory logic where the bundle had to be cut. The fetch unit advances its program counter by four bytes for each slot reported as retired. A combinational read port lets the rest of the pipeline observe any register.

Top module: `quad_issue_alu`

## Requirements
- R1: Every enabled, supported slot ahead of the first cut point executes in the same cycle. Its register write is visible on the read port right after the next rising clock edge. Four `ADDI x1,x1,1` in one bundle advance x1 by exactly four.
- R2: A slot that reads a register written by an earlier live slot of the same bundle uses that slot's new result, not the register-file value.
- R3: Register x0 always reads as zero. A write to x0 is discarded and is never forwarded.
- R4: When several live slots write the same register, the value from the highest-numbered of them is stored.
- R5: A load (opcode 0000011) or store (opcode 0100011) in slot 0 raises `mem_o`, reports a retire count of 1, and writes no register. The later slots of the bundle are held back.
- R6: A load or store in slot 1, 2 or 3 cuts the bundle before that slot. The earlier slots complete, the retire count equals the slot index, and `mem_o` stays low.
- R7: A branch (1100011), JAL (1101111) or JALR (1100111) in slot 0 raises `xfer_o` with a retire count of 1 and no write. In a later slot it cuts the bundle like R6 and `xfer_o` stays low.
- R8: An unsupported encoding cuts the bundle at its slot and raises `illegal_o` if it is reached. This covers shifts (OP-IMM funct3 001/101), an unknown funct7 and unknown opcodes. The retire count is the slot index, and no slot at or after it writes.
- R9: A slot whose `slot_en_i` bit is low, and every slot after it, neither writes nor forwards nor raises a flag.
- R10: `retire_cnt_o` lies between 0 and 4 and counts the contiguous completed slots from slot 0.
- R11: After reset, every register reads as zero.
- R12: The supported operations follow RV32I. The register-register opcode 0110011 covers ADD, SUB (funct7 0100000), AND, OR, XOR, SLT and SLTU. The immediate opcode 0010011 covers ADDI, ANDI, ORI, XORI, SLTI and SLTIU with a sign-extended 12-bit immediate. SLT and SLTI compare signed, SLTU and SLTIU compare unsigned. LUI (0110111) loads imm[31:12] followed by 12 zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, clears the register file |
| instr_i | input | 128 | Four instructions; slot s occupies bits [32*s+31:32*s] |
| slot_en_i | input | 4 | Per-slot valid bits |
| retire_cnt_o | output | 3 | Number of slots retired this cycle (0 to 4) |
| mem_o | output | 1 | Slot 0 holds a load or store |
| xfer_o | output | 1 | Slot 0 holds a branch or jump |
| illegal_o | output | 1 | A reached, enabled slot holds an unsupported encoding |
| rd_addr_i | input | 5 | Register read address |
| rd_data_o | output | 32 | Combinational register read data |

## Verification
The retire count and the three flags are combinational in the bundle and the register file. The bench drives each bundle on a falling edge and samples these outputs a short time later in the same cycle. Register results appear only after the following rising edge. The bench therefore waits for that edge before it steps the read address and compares each register a moment after every address change. The "not written" cases are checked by reading the target register back after that edge. By then any write from the cut slot would already be visible.

// File: rtl/quad_issue_alu.sv
module quad_issue_alu #(
  parameter int SLOTS = 4,
  parameter int XLEN  = 32,
  parameter int NREG  = 32,
  localparam int AW   = $clog2(NREG),
  localparam int CW   = $clog2(SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SLOTS*32-1:0]   instr_i,
  input  logic [SLOTS-1:0]      slot_en_i,
  output logic [CW-1:0]         retire_cnt_o,
  output logic                  mem_o,
  output logic                  xfer_o,
  output logic                  illegal_o,
  input  logic [AW-1:0]         rd_addr_i,
  output logic [XLEN-1:0]       rd_data_o
);

  logic [XLEN-1:0] regs [NREG];
  logic [XLEN-1:0] res  [SLOTS];
  logic [AW-1:0]   dst  [SLOTS];
  logic [SLOTS-1:0] wen;

  assign rd_data_o = (rd_addr_i == '0) ? '0 : regs[rd_addr_i];

  always_comb begin
    logic            reach, legal, special, isload, go;
    logic [31:0]     ins;
    logic [6:0]      opc, f7;
    logic [2:0]      f3;
    logic [AW-1:0]   s1, s2;
    logic [XLEN-1:0] a, b, imm;
    reach = 1'b1;
    retire_cnt_o = '0;
    mem_o = 1'b0;
    xfer_o = 1'b0;
    illegal_o = 1'b0;
    wen = '0;
    for (int s = 0; s < SLOTS; s++) begin
      ins = instr_i[32*s +: 32];
      opc = ins[6:0];
      f3  = ins[14:12];
      f7  = ins[31:25];
      s1  = ins[15+:AW];
      s2  = ins[20+:AW];
      dst[s] = ins[7+:AW];
      imm = {{(XLEN-12){ins[31]}}, ins[31:20]};
      a = (s1 == '0) ? '0 : regs[s1];
      b = (s2 == '0) ? '0 : regs[s2];
      for (int j = 0; j < s; j++) begin
        if (wen[j] && dst[j] == s1) a = res[j];
        if (wen[j] && dst[j] == s2) b = res[j];
      end
      legal = 1'b1;
      special = 1'b0;
      isload = 1'b0;
      res[s] = '0;
      case (opc)
        7'b0010011:
          case (f3)
            3'b000: res[s] = a + imm;
            3'b010: res[s] = {{(XLEN-1){1'b0}}, $signed(a) < $signed(imm)};
            3'b011: res[s] = {{(XLEN-1){1'b0}}, a < imm};
            3'b100: res[s] = a ^ imm;
            3'b110: res[s] = a | imm;
            3'b111: res[s] = a & imm;
            default: legal = 1'b0;
          endcase
        7'b0110011:
          if (f7 == 7'b0100000 && f3 == 3'b000) res[s] = a - b;
          else if (f7 != 7'b0000000) legal = 1'b0;
          else
            case (f3)
              3'b000: res[s] = a + b;
              3'b010: res[s] = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
              3'b011: res[s] = {{(XLEN-1){1'b0}}, a < b};
              3'b100: res[s] = a ^ b;
              3'b110: res[s] = a | b;
              3'b111: res[s] = a & b;
              default: legal = 1'b0;
            endcase
        7'b0110111: res[s] = {ins[31:12], 12'b0};
        7'b0000011, 7'b0100011: begin special = 1'b1; isload = 1'b1; end
        7'b1100011, 7'b1101111, 7'b1100111: special = 1'b1;
        default: legal = 1'b0;
      endcase
      go = reach && slot_en_i[s] && legal && !special;
      wen[s] = go && dst[s] != '0;
      if (reach && slot_en_i[s] && !legal) illegal_o = 1'b1;
      if (reach && slot_en_i[s] && special && s == 0) begin
        retire_cnt_o = CW'(1);
        mem_o  = isload;
        xfer_o = !isload;
      end
      if (go) retire_cnt_o = CW'(s + 1);
      reach = go;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) regs[r] <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++)
        if (wen[s]) regs[dst[s]] <= res[s];
    end
  end

endmodule

// File: rtl/quad_issue_alu_checker.sv
module quad_issue_alu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  slot_en_i,
  input logic [2:0]  retire_cnt_o,
  input logic        mem_o,
  input logic        xfer_o,
  input logic        illegal_o,
  input logic [4:0]  rd_addr_i,
  input logic [31:0] rd_data_o
);
  a_r3_x0_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_i == 5'd0 |-> rd_data_o == 32'd0);
  a_r10_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    retire_cnt_o <= 3'd4);
  a_r5_mem_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_o |-> retire_cnt_o == 3'd1 && !xfer_o && !illegal_o);
  a_r7_xfer_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_o |-> retire_cnt_o == 3'd1 && !mem_o);
  a_r8_illegal_cut: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> retire_cnt_o < 3'd4);
  a_r9_slot0_off: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en_i[0] |-> retire_cnt_o == 3'd0 && !mem_o && !xfer_o && !illegal_o);
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en_i[1] |-> retire_cnt_o <= 3'd1);
endmodule

bind quad_issue_alu quad_issue_alu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .slot_en_i(slot_en_i), .retire_cnt_o(retire_cnt_o),
  .mem_o(mem_o), .xfer_o(xfer_o), .illegal_o(illegal_o),
  .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
);

// File: tb/quad_issue_alu_test.sv
module quad_issue_alu_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] instr_i = '0;
  logic [3:0]   slot_en_i = '0;
  logic [2:0]   retire_cnt_o;
  logic         mem_o, xfer_o, illegal_o;
  logic [4:0]   rd_addr_i = '0;
  logic [31:0]  rd_data_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  quad_issue_alu uut (.*);

  function automatic logic [31:0] opi(int f3, int rd, int rs1, int imm);
    return {imm[11:0], rs1[4:0], f3[2:0], rd[4:0], 7'b0010011};
  endfunction
  function automatic logic [31:0] opr(int f7, int f3, int rd, int rs1, int rs2);
    return {f7[6:0], rs2[4:0], rs1[4:0], f3[2:0], rd[4:0], 7'b0110011};
  endfunction
  function automatic logic [31:0] lui(int rd, int up);
    return {up[19:0], rd[4:0], 7'b0110111};
  endfunction
  localparam logic [31:0] LOADW  = 32'h0000_2683;
  localparam logic [31:0] STOREW = 32'h0000_2023;
  localparam logic [31:0] BEQ0   = 32'h0000_0063;
  localparam logic [31:0] JALX1  = 32'h0080_00ef;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] i0, i1, i2, i3, logic [3:0] en,
                       int cnt, bit m, bit x, bit il, string tag);
    @(negedge clk);
    instr_i = {i3, i2, i1, i0};
    slot_en_i = en;
    #1;
    chk({tag, " R10 count"}, 32'(retire_cnt_o), 32'(cnt));
    chk({tag, " mem"}, 32'(mem_o), 32'(m));
    chk({tag, " xfer"}, 32'(xfer_o), 32'(x));
    chk({tag, " illegal"}, 32'(illegal_o), 32'(il));
    @(posedge clk);
    #1;
    slot_en_i = '0;
  endtask

  task automatic rd(int r, logic [31:0] exp, string tag);
    rd_addr_i = r[4:0];
    #1;
    chk(tag, rd_data_o, exp);
  endtask

  task automatic t_reset;
    for (int r = 0; r < 32; r += 7) rd(r, 0, "R11 reset value");
    rd(31, 0, "R11 reset x31");
  endtask

  task automatic t_incr;
    issue(opi(0,1,1,1), opi(0,1,1,1), opi(0,1,1,1), opi(0,1,1,1), 4'hf, 4, 0, 0, 0, "R1 incr");
    rd(1, 4, "R1 x1 advanced by four");
  endtask

  task automatic t_chain;
    issue(opi(0,2,0,5), opr(0,0,3,2,2), opr(32,0,4,3,2), opr(0,4,5,4,3), 4'hf, 4, 0, 0, 0, "R2 chain");
    rd(3, 10, "R2 add forwarded");
    rd(4, 5, "R2 sub forwarded");
    rd(5, 15, "R2 xor forwarded");
  endtask

  task automatic t_cmp;
    issue(opi(0,6,0,-1), opr(0,2,7,6,0), opr(0,3,8,6,0), lui(9,'h12345), 4'hf, 4, 0, 0, 0, "R12 cmp");
    rd(6, 32'hffff_ffff, "R12 addi negative");
    rd(7, 1, "R12 slt signed");
    rd(8, 0, "R12 sltu unsigned");
    rd(9, 32'h1234_5000, "R12 lui");
    issue(opi(3,20,0,-1), opi(2,21,6,0), opi(6,22,6,'h0f0), opi(7,23,22,'h0ff), 4'hf, 4, 0, 0, 0, "R12 imm");
    rd(20, 1, "R12 sltiu sign-extended imm");
    rd(21, 1, "R12 slti");
    rd(22, 32'hffff_ffff, "R12 ori");
    rd(23, 32'h0000_00ff, "R12 andi");
  endtask

  task automatic t_x0;
    issue(opi(0,0,0,7), opr(0,0,10,0,0), opi(0,24,0,3), opr(0,6,25,24,0), 4'hf, 4, 0, 0, 0, "R3 x0");
    rd(0, 0, "R3 x0 stays zero");
    rd(10, 0, "R3 x0 not forwarded");
    rd(25, 3, "R3 or with x0");
  endtask

  task automatic t_samedst;
    issue(opi(0,11,0,1), opi(0,11,0,2), opi(0,11,0,3), opi(0,12,11,0), 4'hf, 4, 0, 0, 0, "R4 same dest");
    rd(11, 3, "R4 highest slot wins");
    rd(12, 3, "R4 forward from latest writer");
  endtask

  task automatic t_mem;
    issue(LOADW, opi(0,13,0,9), opi(0,13,0,9), opi(0,13,0,9), 4'hf, 1, 1, 0, 0, "R5 load slot0");
    rd(13, 0, "R5 later slots held");
    issue(opi(0,14,0,1), opi(0,14,14,1), STOREW, opi(0,15,0,1), 4'hf, 2, 0, 0, 0, "R6 store slot2");
    rd(14, 2, "R6 earlier slots done");
    rd(15, 0, "R6 slot after cut not written");
  endtask

  task automatic t_xfer;
    issue(BEQ0, opi(0,16,0,1), 0, 0, 4'h3, 1, 0, 1, 0, "R7 branch slot0");
    rd(16, 0, "R7 held after branch");
    issue(opi(0,16,0,4), JALX1, opi(0,16,0,8), 0, 4'h7, 1, 0, 0, 0, "R7 jal slot1");
    rd(16, 4, "R7 cut before jal");
    rd(1, 4, "R7 jal wrote no link");
  endtask

  task automatic t_illegal;
    issue(opi(0,17,0,3), opi(1,17,17,1), opi(0,17,0,9), 0, 4'h7, 1, 0, 0, 1, "R8 shift slot1");
    rd(17, 3, "R8 shift not applied");
    issue(opr(1,0,18,0,0), opi(0,18,0,5), 0, 0, 4'h3, 0, 0, 0, 1, "R8 bad funct7 slot0");
    rd(18, 0, "R8 nothing written");
    issue(opi(0,19,0,2), 32'h0000_007f, 0, 0, 4'h1, 1, 0, 0, 0, "R9 illegal beyond enable");
    rd(19, 2, "R9 slot0 only");
  endtask

  task automatic t_enable;
    issue(opi(0,26,0,1), opi(0,27,0,2), opi(0,28,0,3), opi(0,29,0,4), 4'b1011, 2, 0, 0, 0, "R9 gap");
    rd(26, 1, "R9 slot0 written");
    rd(27, 2, "R9 slot1 written");
    rd(29, 0, "R9 slot3 after gap blocked");
    issue(LOADW, 0, 0, 0, 4'h0, 0, 0, 0, 0, "R9 all off");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_incr;
    t_chain;
    t_cmp;
    t_x0;
    t_samedst;
    t_mem;
    t_xfer;
    t_illegal;
    t_enable;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule